// File: doc/BRIEF.md
# Row/Column Context Broadcast Store

This block holds configuration words for an 8x8 SIMD cell array and sends them out one plane at a time. A loader writes 32-bit words into the store one per cycle. Each word goes into a mode block (row or column), a lane set (0 to 7) and a slot index (0 to 15).

A separate command port asks for a broadcast. It names a mode and a slot index. The block then reads that slot from all eight lane sets of the chosen mode block in parallel. It puts the eight words on a 256-bit context bus, with lane set j in bits [32j+31:32j]. Every cell of row j (row mode) or column j (column mode) takes word j.

An 8-bit lane-enable vector comes with the bus. It has all lanes on, or exactly one lane on when the command asks for a single lane. The single-lane case is used for irregular operations such as loading data or reordering elements. Writes and broadcasts are independent and may happen in the same cycle. Each mode block holds 16 planes, so the store holds 32 planes in total.

Top module: `ctxb_broadcast`

## Requirements
- R1: While reset is asserted and after its release, until the first broadcast command, `bc_valid` is 0, `lane_en` is 0, `bc_col_q` is 0 and `ctx_bus` is all zeros.
- R2: A word written with `wr_en`=1 at (`wr_col`, `wr_set`, `wr_idx`) appears in bits [32*`wr_set`+31 : 32*`wr_set`] of `ctx_bus` on a later broadcast with `bc_col`=`wr_col` and `bc_plane`=`wr_idx`.
- R3: A broadcast command (`bc_go`=1) sampled at a rising edge produces `bc_valid`=1 and the new bus value right after that same edge. There is one register stage of latency.
- R4: `bc_col`=0 selects the row-mode block and `bc_col`=1 selects the column-mode block. The two blocks are fully separate, so a write to one never changes what the other returns.
- R5: A broadcast with `bc_single`=0 drives `lane_en` to 8'hFF.
- R6: A broadcast with `bc_single`=1 drives `lane_en` to a one-hot value with bit `bc_lane` set.
- R7: After a cycle with `bc_go`=0, `bc_valid` and `lane_en` are 0 and `ctx_bus` keeps its previous value.
- R8: A write never stalls or alters a broadcast. If a write and a broadcast hit the same word in the same cycle, the bus carries the value from before the write, and the next broadcast of that slot carries the new value.
- R9: `bc_col_q` reports the mode of the most recent broadcast.
- R10: With `wr_en`=0, activity on the write address and data inputs changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one context word |
| wr_col | input | 1 | Target mode block: 0 row, 1 column |
| wr_set | input | 3 | Target lane set |
| wr_idx | input | 4 | Target slot index inside the set |
| wr_data | input | 32 | Context word to store |
| bc_go | input | 1 | Broadcast command strobe |
| bc_col | input | 1 | Broadcast mode: 0 row, 1 column |
| bc_plane | input | 4 | Plane (slot index) to broadcast |
| bc_single | input | 1 | Enable only one lane |
| bc_lane | input | 3 | Lane enabled when `bc_single`=1 |
| ctx_bus | output | 256 | Eight context words, lane j in bits [32j+31:32j] |
| lane_en | output | 8 | Per-lane execution enable |
| bc_valid | output | 1 | Bus carries a fresh broadcast this cycle |
| bc_col_q | output | 1 | Mode of the current bus contents |

## Verification
The storage array is not reset. The assertions and the model therefore assume that no broadcast reads a slot before it has been written. The stimulus writes every slot of both blocks before issuing its first broadcast. The properties also assume that the command and write inputs are never unknown once reset is released. The bench drives every input to a defined value on each falling edge, including during reset. `bc_lane` is driven with random values even when `bc_single` is 0, so that R5 shows it has no effect in that case.

// File: rtl/ctxb_pkg.sv
package ctxb_pkg;

  typedef enum logic {
    MODE_ROW = 1'b0,
    MODE_COL = 1'b1
  } bc_mode_e;

endpackage

// File: rtl/ctxb_lane_bank.sv
// One lane set: slots for both mode blocks, addressed {mode, index}.
module ctxb_lane_bank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [$clog2(2*DEPTH)-1:0]    wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic [$clog2(2*DEPTH)-1:0]    rd_addr,
  output logic [WORD_W-1:0]             rd_data
);
  localparam int ENTRIES = 2 * DEPTH;

  logic [WORD_W-1:0] store [ENTRIES];

  // Storage array: no reset, written only on an explicit enable.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  // Combinational read; the broadcast register samples the pre-write value.
  assign rd_data = store[rd_addr];

endmodule

// File: rtl/ctxb_lane_decode.sv
// Lane enable decode: all lanes, or one selected lane.
module ctxb_lane_decode #(
  parameter int LANES = 8
) (
  input  logic                       single,
  input  logic [$clog2(LANES)-1:0]   lane,
  output logic [LANES-1:0]           lane_en_d
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_en_d[j] = !single || (lane == j[$clog2(LANES)-1:0]);
  end
endmodule

// File: rtl/ctxb_out_stage.sv
// Output register for bus, lane enables, valid and mode.
module ctxb_out_stage #(
  parameter int LANES  = 8,
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic                       col,
  input  logic [LANES-1:0]           lane_en_d,
  input  logic [LANES*WORD_W-1:0]    bus_d,
  output logic [LANES*WORD_W-1:0]    bus_q,
  output logic [LANES-1:0]           lane_q,
  output logic                       valid_q,
  output logic                       col_q
);
  logic [LANES*WORD_W-1:0] bus_n;
  logic [LANES-1:0]        lane_n;
  logic                    valid_n;
  logic                    col_n;

  always_comb begin
    bus_n   = bus_q;
    col_n   = col_q;
    lane_n  = '0;
    valid_n = go;
    if (go) begin
      bus_n  = bus_d;
      col_n  = col;
      lane_n = lane_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      lane_q  <= '0;
      valid_q <= 1'b0;
      col_q   <= 1'b0;
    end else begin
      bus_q   <= bus_n;
      lane_q  <= lane_n;
      valid_q <= valid_n;
      col_q   <= col_n;
    end
  end
endmodule

// File: rtl/ctxb_broadcast.sv
module ctxb_broadcast
  import ctxb_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic                                   wr_col,
  input  logic [$clog2(LANES)-1:0]               wr_set,
  input  logic [$clog2(DEPTH)-1:0]               wr_idx,
  input  logic [WORD_W-1:0]                      wr_data,
  input  logic                                   bc_go,
  input  logic                                   bc_col,
  input  logic [$clog2(DEPTH)-1:0]               bc_plane,
  input  logic                                   bc_single,
  input  logic [$clog2(LANES)-1:0]               bc_lane,
  output logic [LANES*WORD_W-1:0]                ctx_bus,
  output logic [LANES-1:0]                       lane_en,
  output logic                                   bc_valid,
  output logic                                   bc_col_q
);
  localparam int SET_W  = $clog2(LANES);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 1;

  bc_mode_e              rd_mode;
  bc_mode_e              wr_mode;
  logic [ADDR_W-1:0]     wr_addr;
  logic [ADDR_W-1:0]     rd_addr;
  logic [LANES*WORD_W-1:0] bus_d;
  logic [LANES-1:0]      lane_en_d;

  assign wr_mode = bc_mode_e'(wr_col);
  assign rd_mode = bc_mode_e'(bc_col);
  assign wr_addr = {wr_mode == MODE_COL, wr_idx};
  assign rd_addr = {rd_mode == MODE_COL, bc_plane};

  for (genvar s = 0; s < LANES; s++) begin : g_set
    logic set_we;
    assign set_we = wr_en && (wr_set == s[SET_W-1:0]);
    ctxb_lane_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wr_en   (set_we),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (bus_d[s*WORD_W +: WORD_W])
    );
  end

  ctxb_lane_decode #(.LANES(LANES)) u_dec (
    .single    (bc_single),
    .lane      (bc_lane),
    .lane_en_d (lane_en_d)
  );

  ctxb_out_stage #(.LANES(LANES), .WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (bc_go),
    .col       (bc_col),
    .lane_en_d (lane_en_d),
    .bus_d     (bus_d),
    .bus_q     (ctx_bus),
    .lane_q    (lane_en),
    .valid_q   (bc_valid),
    .col_q     (bc_col_q)
  );

  assert_valid_follows_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bc_go |=> bc_valid);

  assert_idle_holds_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_go |=> (!bc_valid && lane_en == '0 && $stable(ctx_bus)));

  assert_all_lanes_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_go && !bc_single) |=> lane_en == '1);

  assert_one_lane_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_go && bc_single) |=> ($countones(lane_en) == 1 && lane_en[$past(bc_lane)]));

  assert_mode_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bc_go |=> bc_col_q == $past(bc_col));

endmodule

// File: tb/sim_ctxb_broadcast.sv
module sim_ctxb_broadcast;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, wr_col;
  logic [2:0]   wr_set;
  logic [3:0]   wr_idx;
  logic [31:0]  wr_data;
  logic         bc_go, bc_col, bc_single;
  logic [3:0]   bc_plane;
  logic [2:0]   bc_lane;
  logic [255:0] ctx_bus;
  logic [7:0]   lane_en;
  logic         bc_valid, bc_col_q;

  always #2 clk = ~clk;

  ctxb_broadcast u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_col(wr_col), .wr_set(wr_set), .wr_idx(wr_idx), .wr_data(wr_data),
    .bc_go(bc_go), .bc_col(bc_col), .bc_plane(bc_plane), .bc_single(bc_single), .bc_lane(bc_lane),
    .ctx_bus(ctx_bus), .lane_en(lane_en), .bc_valid(bc_valid), .bc_col_q(bc_col_q)
  );

  // Reference model state
  logic [31:0]  ref_mem [2][8][16];
  logic [255:0] e_bus;
  logic [7:0]   e_lane;
  logic         e_valid, e_col;
  int vectors = 0;
  int errs    = 0;
  string tag;

  task automatic compare();
    vectors++;
    if (bc_valid !== e_valid) begin
      errs++;
      $display("FAIL %s R3 bc_valid act=%0b exp=%0b", tag, bc_valid, e_valid);
    end
    if (lane_en !== e_lane) begin
      errs++;
      $display("FAIL %s R5/R6 lane_en act=%h exp=%h", tag, lane_en, e_lane);
    end
    if (ctx_bus !== e_bus) begin
      errs++;
      $display("FAIL %s R2 ctx_bus act=%h exp=%h", tag, ctx_bus, e_bus);
    end
    if (bc_col_q !== e_col) begin
      errs++;
      $display("FAIL %s R9 bc_col_q act=%0b exp=%0b", tag, bc_col_q, e_col);
    end
  endtask

  // Called at a falling edge: drive, predict, advance one cycle, compare.
  task automatic step(input bit we, input bit wc, input bit [2:0] ws, input bit [3:0] wi,
                      input bit [31:0] wd, input bit go, input bit col, input bit [3:0] pl,
                      input bit sg, input bit [2:0] ln, input string t);
    wr_en = we; wr_col = wc; wr_set = ws; wr_idx = wi; wr_data = wd;
    bc_go = go; bc_col = col; bc_plane = pl; bc_single = sg; bc_lane = ln;
    tag = t;
    if (go) begin
      e_valid = 1'b1;
      e_col   = col;
      for (int j = 0; j < 8; j++) e_bus[j*32 +: 32] = ref_mem[col][j][pl];
      e_lane  = sg ? (8'b1 << ln) : 8'hFF;
    end else begin
      e_valid = 1'b0;
      e_lane  = 8'h00;
    end
    if (we) ref_mem[wc][ws][wi] = wd;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog R3 act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_col = 0; wr_set = 0; wr_idx = 0; wr_data = 0;
    bc_go = 0; bc_col = 0; bc_plane = 0; bc_single = 0; bc_lane = 0;
    e_bus = '0; e_lane = '0; e_valid = 1'b0; e_col = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R1 in reset";
    compare();
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after release");

    // Fill both mode blocks; no broadcast yet, bus must hold (R7).
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++)
        for (int i = 0; i < 16; i++)
          step(1, b[0], s[2:0], i[3:0], {b[3:0], s[3:0], i[7:0], $urandom_range(65535)},
               0, 0, 0, 0, 0, "R7 fill");

    // Ignored write activity (R10): random address/data with wr_en low.
    for (int k = 0; k < 20; k++)
      step(0, $urandom_range(1), 3'($urandom_range(7)), 4'($urandom_range(15)), $urandom,
           0, 0, 0, 0, 0, "R10 no write");

    // Every plane, both modes, all lanes (R2 R4 R5).
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++)
        step(0, 0, 0, 0, 0, 1, b[0], i[3:0], 0, 3'($urandom_range(7)), "R2 R4 R5 plane");

    // Single-lane enable for each lane (R6).
    for (int l = 0; l < 8; l++)
      step(0, 0, 0, 0, 0, 1, l[0], 4'(l), 1, l[2:0], "R6 single lane");

    // Write to the other block must not change this block (R4).
    step(1, 1, 3'd2, 4'd7, 32'hC0FFEE01, 1, 0, 4'd7, 0, 0, "R4 block isolation");
    step(0, 0, 0, 0, 0, 1, 0, 4'd7, 0, 0, "R4 block isolation");

    // Same-word collision returns old value, then new (R8).
    step(1, 1, 3'd3, 4'd5, 32'hDEADBEEF, 1, 1, 4'd5, 0, 0, "R8 collision old");
    step(0, 0, 0, 0, 0, 1, 1, 4'd5, 0, 0, "R8 collision new");
    step(1, 0, 3'd0, 4'd0, 32'h12345678, 1, 0, 4'd0, 1, 3'd0, "R8 collision single");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 idle hold");
    step(0, 0, 0, 0, 0, 1, 0, 4'd0, 0, 0, "R8 collision new");

    // Random mixed traffic (R3 R7 R8 R9).
    for (int k = 0; k < 3000; k++)
      step($urandom_range(1), $urandom_range(1), 3'($urandom_range(7)), 4'($urandom_range(15)),
           $urandom, $urandom_range(1), $urandom_range(1), 4'($urandom_range(15)),
           $urandom_range(1), 3'($urandom_range(7)), "R3 R7 R8 R9 random");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule